// File: doc/BRIEF.md
# BCD Clock Calendar Counter

A timekeeping core that keeps seconds, minutes, hours, date, month, day-of-week and a two-digit year, each in packed BCD. It advances by one second for every `PRESCALE` cycles on which the reference enable `ref_en` is high. The default `PRESCALE` of 32768 suits a 32.768 kHz reference enable. A rollover in one field carries into the next field in the same clock cycle. The chain runs from seconds through to the year wrapping from 99 to 00. The date wraps at the true length of each month, and February gets 29 days in leap years.

A host sets any field through a register-style load port: a field select, a data byte and a write strobe. Hours run in 12-hour or 24-hour format, chosen by the top bit of the hours byte. The top bit of the seconds byte is a halt control that freezes both time and the sub-second count. A write to seconds also restarts the sub-second count, so the first whole second after setting the time is a full second long. Illegal loaded values are not corrected. The counters keep stepping and always return to their legal ranges.

Top module: `bcd_timekeeper`

## Requirements
- R1: While `rst_n` is low, and after it rises, the outputs are: seconds 0x00 (running), minutes 0x00, hours 0x00 (24-hour), date 0x01, month 0x01, day 0x01, year 0x00, and `tick_o` low.
- R2: `tick_o` is high, as a function of the current inputs and state, in a cycle with `ref_en` high, no write and no halt when that cycle is the `PRESCALE`-th such cycle. The time fields take their advanced value at the closing clock edge of that cycle. Fields change on no other cycle except through a write.
- R3: Seconds and minutes count 00 to 59 in BCD. 59 wraps to 00 and carries into the next field in the same cycle.
- R4: With hours bit 7 at 0 (24-hour), hours bits 5:0 count 00 to 23 in BCD, with bit 5 as the tens bit for 20 to 23. 23 wraps to 00 and advances date and day.
- R5: With hours bit 7 at 1 (12-hour), bits 4:0 hold 01 to 12 and bit 5 is PM (1 = PM). Stepping from 11 to 12 toggles bit 5. 12 is followed by 01. 11 PM to 12 AM advances date and day. Bit 7 is kept.
- R6: The date wraps to 01 after 28 or 29 (February), 30 (April, June, September, November) or 31 (the other months). February has 29 days when the BCD year is divisible by 4, including 00.
- R7: The month counts 01 to 12 and carries into the year at 12. The year counts 00 to 99 and wraps to 00.
- R8: The day-of-week field advances together with the date at midnight and runs 1 to 7, then back to 1.
- R9: While seconds bit 7 is 1, no field advances and the sub-second count does not move. Writing seconds with bit 7 at 0 restarts counting.
- R10: A write applies at the clock edge to the field chosen by `wr_sel`: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day, 6 year. Select 7 changes nothing. In a write cycle no field advances and the sub-second count holds. Bits outside each field read 0:
  - seconds: bit 7 halt, bits 6:0 value;
  - minutes: bits 6:0;
  - hours: bits 7 and 5:0;
  - date: bits 5:0;
  - month: bits 4:0;
  - day: bits 2:0;
  - year: bits 7:0.
- R11: A write to seconds clears the sub-second count. The next tick comes on the `PRESCALE`-th qualifying `ref_en` cycle after the write.
- R12: Illegal values are not corrected and never lock the counter. For example, seconds loaded with 0x7A step to 0x00 on the next tick without carrying into minutes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_en | input | 1 | Reference enable, one cycle per reference period |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Byte written to the selected field |
| sec_q | output | 8 | Halt bit and BCD seconds |
| min_q | output | 8 | BCD minutes |
| hour_q | output | 8 | Format bit, PM or tens bit, and BCD hours |
| date_q | output | 8 | BCD date |
| month_q | output | 8 | BCD month |
| dow_q | output | 8 | Day of week, 1 to 7 |
| year_q | output | 8 | BCD year |
| tick_o | output | 1 | One-second advance pulse |

## Verification
A host write and a one-second tick can fall in the same cycle. The write then takes the cycle, and the sub-second count holds so that the tick follows on the next reference enable. The bench provokes this by holding `ref_en` high during writes issued while the count sits on its last value. Halt and tick collide in a similar way. Both cases are judged by a behavioural model that is compared against `tick_o` and every field on every clock, and the sub-second count itself is never observed directly.

// File: rtl/tk_pkg.sv
`timescale 1ns/1ps
package tk_pkg;

   typedef enum logic [2:0] {
      TK_SEC   = 3'd0,
      TK_MIN   = 3'd1,
      TK_HOUR  = 3'd2,
      TK_DATE  = 3'd3,
      TK_MONTH = 3'd4,
      TK_DOW   = 3'd5,
      TK_YEAR  = 3'd6,
      TK_NONE  = 3'd7
   } tk_field_e;

   // divisible by 4: tens digit contributes 2 when odd, 0 when even
   function automatic logic leap_bcd(input logic [7:0] yr);
      logic [4:0] sum;
      sum = {3'b000, yr[4], 1'b0} + {1'b0, yr[3:0]};
      return (sum[1:0] == 2'b00);
   endfunction

   function automatic logic [5:0] last_day(input logic [4:0] mon, input logic [7:0] yr);
      case (mon)
         5'h02:                      return leap_bcd(yr) ? 6'h29 : 6'h28;
         5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
         default:                    return 6'h31;
      endcase
   endfunction

endpackage

// File: rtl/tk_prescaler.sv
`timescale 1ns/1ps
module tk_prescaler #(
   parameter int PRESCALE = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_en,
   input  logic hold,
   input  logic clear,
   output logic tick
);
   localparam int CW = $clog2(PRESCALE);
   localparam bit POW2 = ((PRESCALE & (PRESCALE - 1)) == 0);

   logic [CW-1:0] cnt;
   logic          at_end;

   generate
      if (PRESCALE < 2) begin : g_bad_prescale
         $error("tk_prescaler: PRESCALE must be at least 2");
      end
      if (POW2) begin : g_pow2
         assign at_end = &cnt;
      end else begin : g_cmp
         assign at_end = (cnt == CW'(PRESCALE - 1));
      end
   endgenerate

   assign tick = ref_en & ~hold & ~clear & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (ref_en && !hold)
         cnt <= at_end ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/tk_bcd_step.sv
`timescale 1ns/1ps
module tk_bcd_step #(
   parameter int W = 7
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] lim,
   input  logic [W-1:0] first,
   output logic [W-1:0] nxt,
   output logic         wrap
);
   assign wrap = (cur == lim);

   generate
      if (W < 3 || W > 8) begin : g_bad_width
         $error("tk_bcd_step: W must be 3 to 8");
      end
      if (W <= 4) begin : g_single
         localparam logic [W-1:0] ONE = 1;
         assign nxt = wrap ? first : cur + ONE;
      end else begin : g_two_digit
         localparam int HW = W - 4;
         localparam logic [HW-1:0] ONE_HI = 1;
         logic [3:0]    lo;
         logic [HW-1:0] hi;
         assign lo = cur[3:0];
         assign hi = cur[W-1:4];
         always_comb begin
            if (wrap)
               nxt = first;
            else if (lo >= 4'd9)
               nxt = {hi + ONE_HI, 4'h0};
            else
               nxt = {hi, lo + 4'd1};
         end
      end
   endgenerate
endmodule

// File: rtl/tk_hour_step.sv
`timescale 1ns/1ps
module tk_hour_step (
   input  logic       mode12,
   input  logic [5:0] cur,
   output logic [5:0] nxt,
   output logic       day_carry
);
   logic       pm;
   logic [4:0] v;

   always_comb begin
      pm        = cur[5];
      v         = cur[4:0];
      nxt       = cur;
      day_carry = 1'b0;
      if (mode12) begin
         if (v == 5'h12)
            v = 5'h01;
         else if (v[3:0] >= 4'd9)
            v = {~v[4], 4'h0};
         else
            v = {v[4], v[3:0] + 4'd1};
         if (cur[4:0] == 5'h11) begin
            pm        = ~cur[5];
            day_carry = cur[5];
         end
         nxt = {pm, v};
      end else begin
         if (cur == 6'h23) begin
            nxt       = 6'h00;
            day_carry = 1'b1;
         end else if (cur[3:0] >= 4'd9) begin
            nxt = {cur[5:4] + 2'd1, 4'h0};
         end else begin
            nxt = {cur[5:4], cur[3:0] + 4'd1};
         end
      end
   end
endmodule

// File: rtl/bcd_timekeeper.sv
`timescale 1ns/1ps
module bcd_timekeeper #(
   parameter int PRESCALE = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_en,
   input  logic       wr_en,
   input  logic [2:0] wr_sel,
   input  logic [7:0] wr_data,
   output logic [7:0] sec_q,
   output logic [7:0] min_q,
   output logic [7:0] hour_q,
   output logic [7:0] date_q,
   output logic [7:0] month_q,
   output logic [7:0] dow_q,
   output logic [7:0] year_q,
   output logic       tick_o
);
   import tk_pkg::*;

   logic       halt_r, h12_r;
   logic [6:0] sec_r, min_r;
   logic [5:0] hour_r, date_r;
   logic [4:0] mon_r;
   logic [2:0] dow_r;
   logic [7:0] year_r;

   logic [6:0] sec_nxt, min_nxt;
   logic [5:0] hour_nxt, date_nxt;
   logic [4:0] mon_nxt;
   logic [2:0] dow_nxt;
   logic [7:0] year_nxt;
   logic sec_wrap, min_wrap, day_carry, date_wrap, mon_wrap, dow_wrap, year_wrap;
   logic min_en, hour_en, day_en, mon_en, year_en;
   logic sec_write;

   assign sec_write = wr_en && (wr_sel == TK_SEC);

   tk_prescaler #(.PRESCALE(PRESCALE)) u_prescaler (
      .clk   (clk),
      .rst_n (rst_n),
      .ref_en(ref_en),
      .hold  (halt_r | wr_en),
      .clear (sec_write),
      .tick  (tick_o)
   );

   tk_bcd_step #(.W(7)) u_sec (.cur(sec_r), .lim(7'h59), .first(7'h00),
                               .nxt(sec_nxt), .wrap(sec_wrap));
   tk_bcd_step #(.W(7)) u_min (.cur(min_r), .lim(7'h59), .first(7'h00),
                               .nxt(min_nxt), .wrap(min_wrap));
   tk_hour_step u_hour (.mode12(h12_r), .cur(hour_r), .nxt(hour_nxt), .day_carry(day_carry));
   tk_bcd_step #(.W(6)) u_date (.cur(date_r), .lim(last_day(mon_r, year_r)), .first(6'h01),
                                .nxt(date_nxt), .wrap(date_wrap));
   tk_bcd_step #(.W(3)) u_dow (.cur(dow_r), .lim(3'd7), .first(3'd1),
                               .nxt(dow_nxt), .wrap(dow_wrap));
   tk_bcd_step #(.W(5)) u_mon (.cur(mon_r), .lim(5'h12), .first(5'h01),
                               .nxt(mon_nxt), .wrap(mon_wrap));
   tk_bcd_step #(.W(8)) u_year (.cur(year_r), .lim(8'h99), .first(8'h00),
                                .nxt(year_nxt), .wrap(year_wrap));

   // ripple of enables: every field settles in the tick cycle
   assign min_en  = tick_o  & sec_wrap;
   assign hour_en = min_en  & min_wrap;
   assign day_en  = hour_en & day_carry;
   assign mon_en  = day_en  & date_wrap;
   assign year_en = mon_en  & mon_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_r <= 1'b0;
         sec_r  <= 7'h00;
         min_r  <= 7'h00;
         h12_r  <= 1'b0;
         hour_r <= 6'h00;
         date_r <= 6'h01;
         mon_r  <= 5'h01;
         dow_r  <= 3'd1;
         year_r <= 8'h00;
      end else if (wr_en) begin
         case (tk_field_e'(wr_sel))
            TK_SEC:   begin halt_r <= wr_data[7]; sec_r <= wr_data[6:0]; end
            TK_MIN:   min_r <= wr_data[6:0];
            TK_HOUR:  begin h12_r <= wr_data[7]; hour_r <= wr_data[5:0]; end
            TK_DATE:  date_r <= wr_data[5:0];
            TK_MONTH: mon_r <= wr_data[4:0];
            TK_DOW:   dow_r <= wr_data[2:0];
            TK_YEAR:  year_r <= wr_data;
            default:  ;
         endcase
      end else begin
         if (tick_o)  sec_r  <= sec_nxt;
         if (min_en)  min_r  <= min_nxt;
         if (hour_en) hour_r <= hour_nxt;
         if (day_en) begin
            date_r <= date_nxt;
            dow_r  <= dow_nxt;
         end
         if (mon_en)  mon_r  <= mon_nxt;
         if (year_en) year_r <= year_nxt;
      end
   end

   assign sec_q   = {halt_r, sec_r};
   assign min_q   = {1'b0, min_r};
   assign hour_q  = {h12_r, 1'b0, hour_r};
   assign date_q  = {2'b00, date_r};
   assign month_q = {3'b000, mon_r};
   assign dow_q   = {5'b00000, dow_r};
   assign year_q  = year_r;
endmodule

// File: rtl/tk_checker.sv
`timescale 1ns/1ps
module tk_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [2:0] wr_sel,
   input logic [7:0] wr_data,
   input logic [7:0] sec_q,
   input logic [7:0] min_q,
   input logic [7:0] hour_q,
   input logic [7:0] date_q,
   input logic [7:0] month_q,
   input logic [7:0] dow_q,
   input logic [7:0] year_q,
   input logic       tick_o
);
   logic at_top_of_hour;
   assign at_top_of_hour = tick_o && (sec_q[6:0] == 7'h59) && (min_q == 8'h59);

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_o && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) &&
                               $stable(date_q) && $stable(month_q) && $stable(dow_q) &&
                               $stable(year_q)));

   assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && sec_q[6:0] == 7'h59) |=> (sec_q[6:0] == 7'h00 && min_q != $past(min_q)));

   assert_noon_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (at_top_of_hour && hour_q[7] && hour_q[4:0] == 5'h11)
      |=> (hour_q[4:0] == 5'h12 && hour_q[5] != $past(hour_q[5]) && hour_q[7]));

   assert_dow_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (at_top_of_hour && !hour_q[7] && hour_q[5:0] == 6'h23 && dow_q == 8'd7)
      |=> (dow_q == 8'd1));

   assert_halt_no_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sec_q[7] |-> !tick_o);

   assert_write_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !tick_o);

   assert_year_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 3'd6) |=> (year_q == $past(wr_data)));

   assert_sec_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 3'd0) |=> !tick_o);
endmodule

bind bcd_timekeeper tk_checker u_tk_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .wr_sel (wr_sel),
   .wr_data(wr_data),
   .sec_q  (sec_q),
   .min_q  (min_q),
   .hour_q (hour_q),
   .date_q (date_q),
   .month_q(month_q),
   .dow_q  (dow_q),
   .year_q (year_q),
   .tick_o (tick_o)
);

// File: tb/test_bcd_timekeeper.sv
`timescale 1ns/1ps
module test_bcd_timekeeper;
   localparam int P = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_en = 1'b0, wr_en = 1'b0;
   logic [2:0] wr_sel = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] sec_q, min_q, hour_q, date_q, month_q, dow_q, year_q;
   logic tick_o;

   int checks = 0, failures = 0;
   bit done = 1'b0;

   // reference model state
   int m_halt, m_sec, m_min, m_mode, m_hr, m_date, m_mon, m_dow, m_year, m_cnt;
   int ticks_seen = 0;

   always #4 clk = ~clk;

   bcd_timekeeper #(.PRESCALE(P)) i_bcd_timekeeper (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q),
      .date_q(date_q), .month_q(month_q), .dow_q(dow_q), .year_q(year_q), .tick_o(tick_o)
   );

   function automatic int inc_bcd(int v, int hibits);
      int lo = v % 16, hi = v / 16;
      if (lo >= 9) begin lo = 0; hi = (hi + 1) % (1 << hibits); end
      else lo = lo + 1;
      return hi * 16 + lo;
   endfunction

   function automatic int month_days(int mon, int yr);
      int dec = (yr / 16) * 10 + (yr % 16);
      if (mon == 'h02) return (dec % 4 == 0) ? 'h29 : 'h28;
      if (mon == 'h04 || mon == 'h06 || mon == 'h09 || mon == 'h11) return 'h30;
      return 'h31;
   endfunction

   task automatic model_advance();
      int pm, v, lim;
      bit c, day;
      c = (m_sec == 'h59);
      m_sec = c ? 0 : inc_bcd(m_sec, 3);
      if (!c) return;
      c = (m_min == 'h59);
      m_min = c ? 0 : inc_bcd(m_min, 3);
      if (!c) return;
      if (m_mode == 1) begin
         pm = m_hr / 32; v = m_hr % 32;
         day = (v == 'h11) && (pm == 1);
         if (v == 'h11) pm = 1 - pm;
         v = (v == 'h12) ? 1 : inc_bcd(v, 1);
         m_hr = pm * 32 + v;
      end else begin
         day = (m_hr == 'h23);
         m_hr = day ? 0 : inc_bcd(m_hr, 2);
      end
      if (!day) return;
      m_dow = (m_dow == 7) ? 1 : (m_dow + 1) % 8;
      lim = month_days(m_mon, m_year);
      c = (m_date == lim);
      m_date = c ? 1 : inc_bcd(m_date, 2);
      if (!c) return;
      c = (m_mon == 'h12);
      m_mon = c ? 1 : inc_bcd(m_mon, 1);
      if (!c) return;
      m_year = (m_year == 'h99) ? 0 : inc_bcd(m_year, 4);
   endtask

   function automatic bit exp_tick();
      return rst_n && ref_en && !wr_en && m_halt == 0 && m_cnt == P - 1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_halt = 0; m_sec = 0; m_min = 0; m_mode = 0; m_hr = 0;
         m_date = 1; m_mon = 1; m_dow = 1; m_year = 0; m_cnt = 0;
      end else if (wr_en) begin
         case (wr_sel)
            3'd0: begin m_halt = wr_data[7]; m_sec = wr_data & 8'h7F; m_cnt = 0; end
            3'd1: m_min = wr_data & 8'h7F;
            3'd2: begin m_mode = wr_data[7]; m_hr = wr_data & 8'h3F; end
            3'd3: m_date = wr_data & 8'h3F;
            3'd4: m_mon = wr_data & 8'h1F;
            3'd5: m_dow = wr_data & 8'h07;
            3'd6: m_year = wr_data;
            default: ;
         endcase
      end else if (ref_en && m_halt == 0) begin
         if (m_cnt == P - 1) begin m_cnt = 0; ticks_seen++; model_advance(); end
         else m_cnt++;
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R3", "seconds", sec_q, m_halt * 128 + m_sec);
      chk("R3", "minutes", min_q, m_min);
      chk("R4", "hours", hour_q, m_mode * 128 + m_hr);
      chk("R6", "date", date_q, m_date);
      chk("R7", "month", month_q, m_mon);
      chk("R8", "day", dow_q, m_dow);
      chk("R7", "year", year_q, m_year);
      chk("R2", "tick", tick_o, exp_tick());
   endtask

   task automatic cyc(bit we, logic [2:0] sel, logic [7:0] d, bit r);
      @(negedge clk);
      wr_en = we; wr_sel = sel; wr_data = d; ref_en = r;
      #1 compare_all();
   endtask

   task automatic wr(logic [2:0] sel, logic [7:0] d);
      cyc(1'b1, sel, d, 1'b0);
   endtask

   task automatic pulses(int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'h00, 1'b1);
      cyc(1'b0, 3'd0, 8'h00, 1'b0);
   endtask

   task automatic to_midnight(logic [7:0] hr);
      wr(3'd2, hr); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
      pulses(P);
   endtask

   initial begin
      int snap_t;
      logic [7:0] snap [7];
      repeat (3) cyc(1'b0, 3'd0, 8'h00, 1'b0);
      // R1: reset values
      chk("R1", "sec", sec_q, 8'h00); chk("R1", "hour", hour_q, 8'h00);
      chk("R1", "date", date_q, 8'h01); chk("R1", "month", month_q, 8'h01);
      chk("R1", "dow", dow_q, 8'h01); chk("R1", "year", year_q, 8'h00);
      rst_n = 1'b1;
      cyc(1'b0, 3'd0, 8'h00, 1'b0);
      chk("R1", "min after release", min_q, 8'h00);

      // R2: three seconds of continuous reference enables
      pulses(3 * P);
      chk("R2", "sec after 3 periods", sec_q, 8'h03);
      chk("R2", "tick count", ticks_seen, 3);
      // R2: sparse enables, every other cycle
      for (int i = 0; i < 2 * P; i++) cyc(1'b0, 3'd0, 8'h00, i[0]);
      cyc(1'b0, 3'd0, 8'h00, 1'b0);
      chk("R2", "sec sparse", sec_q, 8'h04);

      // R3 R4 R7 R8: full rollover at new year
      wr(3'd0, 8'h58); wr(3'd1, 8'h59); wr(3'd2, 8'h23); wr(3'd3, 8'h31);
      wr(3'd4, 8'h12); wr(3'd5, 8'h07); wr(3'd6, 8'h99);
      pulses(P);
      chk("R3", "sec 59", sec_q, 8'h59);
      pulses(P);
      chk("R3", "sec wrap", sec_q, 8'h00); chk("R3", "min wrap", min_q, 8'h00);
      chk("R4", "hour wrap", hour_q, 8'h00); chk("R6", "date wrap", date_q, 8'h01);
      chk("R7", "month wrap", month_q, 8'h01); chk("R7", "year wrap", year_q, 8'h00);
      chk("R8", "dow wrap", dow_q, 8'h01);
      // R4: 19 -> 20 uses bit 5
      wr(3'd2, 8'h19); wr(3'd1, 8'h59); wr(3'd0, 8'h59); pulses(P);
      chk("R4", "hour 20", hour_q, 8'h20);

      // R5: 12-hour format
      to_midnight(8'h91);
      chk("R5", "11AM->12PM", hour_q, 8'hB2);
      wr(3'd1, 8'h59); wr(3'd0, 8'h59); pulses(P);
      chk("R5", "12PM->1PM", hour_q, 8'hA1);
      wr(3'd3, 8'h05); wr(3'd5, 8'h03);
      to_midnight(8'hB1);
      chk("R5", "11PM->12AM", hour_q, 8'h92);
      chk("R5", "date on 12AM", date_q, 8'h06);
      chk("R8", "dow on 12AM", dow_q, 8'h04);

      // R6: month lengths and leap years
      wr(3'd6, 8'h24); wr(3'd4, 8'h02); wr(3'd3, 8'h28); to_midnight(8'h23);
      chk("R6", "leap feb 29", date_q, 8'h29);
      to_midnight(8'h23);
      chk("R6", "leap mar 1", month_q, 8'h03);
      wr(3'd6, 8'h23); wr(3'd4, 8'h02); wr(3'd3, 8'h28); to_midnight(8'h23);
      chk("R6", "common feb", date_q, 8'h01);
      wr(3'd6, 8'h00); wr(3'd4, 8'h02); wr(3'd3, 8'h28); to_midnight(8'h23);
      chk("R6", "year 00 leap", date_q, 8'h29);
      wr(3'd4, 8'h04); wr(3'd3, 8'h30); to_midnight(8'h23);
      chk("R6", "april 30", month_q, 8'h05);
      wr(3'd4, 8'h01); wr(3'd3, 8'h30); to_midnight(8'h23);
      chk("R6", "jan 31", date_q, 8'h31);

      // R9: halt
      wr(3'd0, 8'h85);
      snap_t = ticks_seen;
      for (int i = 0; i < 5 * P; i++) cyc(1'b0, 3'd0, 8'h00, 1'b1);
      chk("R9", "halted sec", sec_q, 8'h85);
      chk("R9", "no ticks halted", ticks_seen, snap_t);
      wr(3'd0, 8'h05);
      pulses(P - 1);
      chk("R9", "restart partial", sec_q, 8'h05);
      pulses(1);
      chk("R9", "restart tick", sec_q, 8'h06);

      // R11: seconds write clears the sub-second count
      pulses(2);
      wr(3'd0, 8'h10);
      pulses(P - 1);
      chk("R11", "no early tick", sec_q, 8'h10);
      pulses(1);
      chk("R11", "tick after full period", sec_q, 8'h11);

      // R10: write collides with a due tick, then select 7
      pulses(P - 1);
      cyc(1'b1, 3'd1, 8'h42, 1'b1);
      chk("R10", "tick suppressed", tick_o, 0);
      cyc(1'b0, 3'd0, 8'h00, 1'b0);
      chk("R10", "min loaded", min_q, 8'h42);
      chk("R10", "sec held", sec_q, 8'h11);
      pulses(1);
      chk("R10", "deferred tick", sec_q, 8'h12);
      snap = '{sec_q, min_q, hour_q, date_q, month_q, dow_q, year_q};
      cyc(1'b1, 3'd7, 8'hFF, 1'b0);
      cyc(1'b0, 3'd0, 8'h00, 1'b0);
      chk("R10", "sel7 sec", sec_q, snap[0]); chk("R10", "sel7 min", min_q, snap[1]);
      chk("R10", "sel7 hour", hour_q, snap[2]); chk("R10", "sel7 year", year_q, snap[6]);
      wr(3'd5, 8'hFE); cyc(1'b0, 3'd0, 8'h00, 1'b0);
      chk("R10", "dow masked", dow_q, 8'h06);

      // R12: illegal values keep counting
      wr(3'd1, 8'h30); wr(3'd0, 8'h7A); pulses(P);
      chk("R12", "sec 7A steps", sec_q, 8'h00);
      chk("R12", "no minute carry", min_q, 8'h30);
      wr(3'd5, 8'h00); to_midnight(8'h23);
      chk("R12", "dow 0 steps", dow_q, 8'h01);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule